// File: doc/BRIEF.md
# Self-Interrupt Register with Request Logging

This block gives local software a single write-only register through which it can raise an interrupt on its own core. Software supplies only an 8-bit vector. The write is handled as a self-targeted, fixed-delivery, edge-triggered request. That request is logged at once in a 256-entry pending-request vector, and the matching trigger-mode entry is updated.

The block keeps three per-vector state vectors: pending, in-service and trigger-mode. These same vectors also record requests that arrive from the system side, which carry their own trigger level. The core takes a pending vector through an acknowledge input, which moves that vector's bit from pending to in-service. An end-of-interrupt pulse retires the highest-numbered in-service vector.

On the register bus, the completion pulse for a write comes only after the pending bit for that vector is already set. Any read of the register produces an error response and no data.

Top module: `self_irq_logger`

## Requirements
- R1: A write strobe at address 0x83F sets the pending bit selected by write-data bits 7:0. The bit is visible on `pend_vec` in the cycle after the strobe.
- R2: Write-data bits 31:8 are ignored. Nonzero values there neither change the logged vector nor raise `rsp_err`.
- R3: A logged self write clears the trigger-mode bit of its vector, because the request is edge-triggered. The exception is a system request for the same vector in the same cycle, whose level then wins.
- R4: `rsp_done` pulses for exactly one cycle after an accepted write. In that cycle the vector's pending bit already reads 1.
- R5: A read strobe at address 0x83F pulses `rsp_err` in the next cycle. It never raises `rsp_done` and changes no state.
- R6: A write whose vector is already pending leaves `pend_vec` unchanged, so both requests merge into one. It still completes with `rsp_done`.
- R7: A system request sets the pending bit of its vector. It also loads that vector's trigger-mode bit with the supplied level (1 for level, 0 for edge).
- R8: An acknowledge clears the pending bit of its vector and sets the in-service bit in the same clock edge.
- R9: An end-of-interrupt pulse clears the highest-numbered set in-service bit and leaves the other in-service bits untouched. If no bit is set, the pulse does nothing.
- R10: When an acknowledge and a new request for the same vector arrive in the same cycle, the pending bit stays 1 and the in-service bit becomes 1.
- R11: Reads and writes at any address other than 0x83F change no state and produce neither `rsp_done` nor `rsp_err`.
- R12: After reset, all pending, in-service and trigger-mode bits read 0, and `rsp_done` and `rsp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 32 | Write data (vector in bits 7:0) |
| rsp_done | output | 1 | Write completion pulse |
| rsp_err | output | 1 | Access-fault pulse for a read |
| sys_valid | input | 1 | System-side request strobe |
| sys_vector | input | 8 | System-side request vector |
| sys_level | input | 1 | System-side trigger mode (1 = level) |
| ack_valid | input | 1 | Core acknowledge strobe |
| ack_vector | input | 8 | Vector being acknowledged |
| eoi | input | 1 | End-of-interrupt pulse |
| pend_vec | output | 256 | Pending-request bits |
| serv_vec | output | 256 | In-service bits |
| trig_vec | output | 256 | Trigger-mode bits |

## Verification
The bench builds the block with its default parameters: 256 vectors, an 8-bit vector field and a 12-bit address. With these values both end vectors, 0 and 255, can be reached directly. The end-of-interrupt search can therefore be driven across the full width, including the top bit. The bench also covers same-vector collisions between self writes, system requests and acknowledges, and the merging of repeated writes, all against the real register address.

// File: rtl/self_irq_pkg.sv
package self_irq_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_VEC  = 256;
  localparam int unsigned VEC_W    = $clog2(NUM_VEC);
  localparam logic [ADDR_W-1:0] SELF_ADDR = 12'h83F;
endpackage

// File: rtl/self_irq_bus.sv
module self_irq_bus
  import self_irq_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned VW   = VEC_W,
  parameter logic [AW-1:0] REG_ADDR = SELF_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          set_valid,
  output logic [VW-1:0] set_vec,
  output logic          done,
  output logic          err
);
  logic hit;
  logic done_n, err_n;

  always_comb begin
    hit       = (addr == REG_ADDR);
    set_valid = wr && hit;
    set_vec   = wdata[VW-1:0];
    done_n    = wr && hit;
    err_n     = rd && hit && !wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= done_n;
      err  <= err_n;
    end
  end
endmodule

// File: rtl/self_irq_top_find.sv
module self_irq_top_find #(
  parameter int unsigned N = 256
) (
  input  logic [N-1:0] bits,
  output logic [N-1:0] top_mask
);
  always_comb begin
    top_mask = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        top_mask    = '0;
        top_mask[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/self_irq_state.sv
module self_irq_state #(
  parameter int unsigned N  = 256,
  parameter int unsigned VW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          self_set,
  input  logic [VW-1:0] self_vec,
  input  logic          sys_set,
  input  logic [VW-1:0] sys_vec,
  input  logic          sys_lvl,
  input  logic          ack_set,
  input  logic [VW-1:0] ack_vec,
  input  logic [N-1:0]  eoi_clr,
  output logic [N-1:0]  pend_q,
  output logic [N-1:0]  serv_q,
  output logic [N-1:0]  trig_q
);
  for (genvar g = 0; g < N; g++) begin : g_vec
    logic self_hit, sys_hit, ack_hit, bit_en;
    logic pend_n, serv_n, trig_n;

    always_comb begin
      self_hit = self_set && (self_vec == VW'(g));
      sys_hit  = sys_set  && (sys_vec  == VW'(g));
      ack_hit  = ack_set  && (ack_vec  == VW'(g));
      bit_en   = self_hit || sys_hit || ack_hit || eoi_clr[g];
      pend_n   = self_hit || sys_hit || (pend_q[g] && !ack_hit);
      serv_n   = ack_hit || (serv_q[g] && !eoi_clr[g]);
      if (sys_hit)       trig_n = sys_lvl;
      else if (self_hit) trig_n = 1'b0;
      else               trig_n = trig_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
        serv_q[g] <= 1'b0;
        trig_q[g] <= 1'b0;
      end else if (bit_en) begin
        pend_q[g] <= pend_n;
        serv_q[g] <= serv_n;
        trig_q[g] <= trig_n;
      end
    end
  end
endmodule

// File: rtl/self_irq_logger.sv
module self_irq_logger
  import self_irq_pkg::*;
#(
  parameter int unsigned N_VEC = NUM_VEC,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W,
  localparam int unsigned VW   = $clog2(N_VEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          rsp_done,
  output logic          rsp_err,
  input  logic          sys_valid,
  input  logic [VW-1:0] sys_vector,
  input  logic          sys_level,
  input  logic          ack_valid,
  input  logic [VW-1:0] ack_vector,
  input  logic          eoi,
  output logic [N_VEC-1:0] pend_vec,
  output logic [N_VEC-1:0] serv_vec,
  output logic [N_VEC-1:0] trig_vec
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             set_valid;
  logic [VW-1:0]    set_vec;
  logic [N_VEC-1:0] top_mask;
  logic [N_VEC-1:0] eoi_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  always_comb begin
    rst_int_n = rst_sync_q[1];
    eoi_clr   = eoi ? top_mask : '0;
  end

  self_irq_bus #(
    .AW(AW), .DW(DW), .VW(VW), .REG_ADDR(SELF_ADDR)
  ) i_bus (
    .clk(clk), .rst_n(rst_int_n),
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
    .set_valid(set_valid), .set_vec(set_vec),
    .done(rsp_done), .err(rsp_err)
  );

  self_irq_top_find #(.N(N_VEC)) i_find (
    .bits(serv_vec), .top_mask(top_mask)
  );

  self_irq_state #(.N(N_VEC), .VW(VW)) i_state (
    .clk(clk), .rst_n(rst_int_n),
    .self_set(set_valid), .self_vec(set_vec),
    .sys_set(sys_valid), .sys_vec(sys_vector), .sys_lvl(sys_level),
    .ack_set(ack_valid), .ack_vec(ack_vector),
    .eoi_clr(eoi_clr),
    .pend_q(pend_vec), .serv_q(serv_vec), .trig_q(trig_vec)
  );
endmodule

// File: rtl/self_irq_logger_chk.sv
module self_irq_logger_chk #(
  parameter int unsigned N_VEC = 256,
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 32,
  parameter int unsigned VW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic          sys_valid,
  input logic [VW-1:0] sys_vector,
  input logic          sys_level,
  input logic          ack_valid,
  input logic [VW-1:0] ack_vector,
  input logic          eoi,
  input logic [N_VEC-1:0] pend_vec,
  input logic [N_VEC-1:0] serv_vec,
  input logic [N_VEC-1:0] trig_vec
);
  logic          wr_hit, rd_hit;
  logic [VW-1:0] wvec;
  always_comb begin
    wr_hit = bus_wr && (bus_addr == 12'h83F);
    rd_hit = bus_rd && !bus_wr && (bus_addr == 12'h83F);
    wvec   = bus_wdata[VW-1:0];
  end

  a_r4_done_after_log: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> rsp_done && pend_vec[$past(wvec)]);

  a_r5_read_faults: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rsp_err && !rsp_done);

  a_r11_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !rd_hit) |=> !rsp_done && !rsp_err);

  a_r3_edge_clears_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !(sys_valid && sys_vector == wvec)) |=> !trig_vec[$past(wvec)]);

  a_r8_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !(wr_hit && wvec == ack_vector) && !(sys_valid && sys_vector == ack_vector))
      |=> !pend_vec[$past(ack_vector)] && serv_vec[$past(ack_vector)]);

  a_r10_collide_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && wr_hit && wvec == ack_vector)
      |=> pend_vec[$past(ack_vector)] && serv_vec[$past(ack_vector)]);

  a_r9_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_valid && serv_vec != '0)
      |=> $countones(serv_vec) + 1 == $countones($past(serv_vec)));
endmodule

bind self_irq_logger self_irq_logger_chk #(
  .N_VEC(N_VEC), .AW(AW), .DW(DW), .VW(VW)
) i_chk (.*);

// File: tb/test_self_irq_logger.sv
module test_self_irq_logger;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         sys_valid = 1'b0, sys_level = 1'b0;
  logic [7:0]   sys_vector = '0;
  logic         ack_valid = 1'b0;
  logic [7:0]   ack_vector = '0;
  logic         eoi = 1'b0;
  logic         rsp_done, rsp_err;
  logic [255:0] pend_vec, serv_vec, trig_vec;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [255:0] m_pend = '0, m_serv = '0, m_trig = '0;
  logic         m_done = 0, m_err = 0;

  always #2 clk = ~clk;

  self_irq_logger i_self_irq_logger (.*);

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference model: updates on each rising edge from the inputs held since the last falling edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_serv = '0; m_trig = '0; m_done = 0; m_err = 0;
    end else begin
      bit whit, rhit;
      int top;
      whit = bus_wr && bus_addr == 12'h83F;
      rhit = bus_rd && !bus_wr && bus_addr == 12'h83F;
      top = -1;
      for (int i = 0; i < 256; i++) if (m_serv[i]) top = i;
      if (eoi && top >= 0) m_serv[top] = 1'b0;
      if (ack_valid) begin
        m_pend[ack_vector] = 1'b0;
        m_serv[ack_vector] = 1'b1;
      end
      if (whit) begin
        m_pend[bus_wdata[7:0]] = 1'b1;
        m_trig[bus_wdata[7:0]] = 1'b0;
      end
      if (sys_valid) begin
        m_pend[sys_vector] = 1'b1;
        m_trig[sys_vector] = sys_level;
      end
      m_done = whit;
      m_err  = rhit;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(pend_vec == m_pend, "R1/R6/R7 pending model", pend_vec, m_pend);
      chk(serv_vec == m_serv, "R8/R9 in-service model", serv_vec, m_serv);
      chk(trig_vec == m_trig, "R3/R7 trigger model", trig_vec, m_trig);
      chk(rsp_done == m_done, "R4 done model", 256'(rsp_done), 256'(m_done));
      chk(rsp_err == m_err, "R5 err model", 256'(rsp_err), 256'(m_err));
    end
  end

  task automatic idle();
    bus_wr = 0; bus_rd = 0; sys_valid = 0; ack_valid = 0; eoi = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [255:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(pend_vec == '0 && serv_vec == '0 && trig_vec == '0 && !rsp_done && !rsp_err,
        "R12 reset", pend_vec | serv_vec | trig_vec, '0);

    // R1 R2 R4: write 0x41 with junk in reserved bits
    wr(12'h83F, 32'hDEAD_BE41);
    chk(pend_vec[8'h41] == 1'b1, "R1 pending set", 256'(pend_vec[8'h41]), 256'd1);
    chk(rsp_done == 1'b1, "R4 done with pending set", 256'(rsp_done), 256'd1);
    chk(rsp_err == 1'b0, "R2 reserved bits no error", 256'(rsp_err), 256'd0);
    chk($countones(pend_vec) == 1, "R2 only vector 0x41", pend_vec, 256'd1 << 8'h41);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R4 done single pulse", 256'(rsp_done), 256'd0);

    // R6 merge
    snap = pend_vec;
    wr(12'h83F, 32'h0000_0041);
    chk(pend_vec == snap && rsp_done, "R6 merge", pend_vec, snap);

    // R5 read faults
    snap = pend_vec;
    rd(12'h83F);
    chk(rsp_err == 1'b1 && rsp_done == 1'b0, "R5 read error", 256'(rsp_err), 256'd1);
    chk(pend_vec == snap, "R5 read no state change", pend_vec, snap);

    // R11 other address
    wr(12'h83E, 32'h0000_0022);
    chk(pend_vec[8'h22] == 1'b0 && !rsp_done, "R11 stray write ignored", pend_vec, snap);
    rd(12'h000);
    chk(rsp_err == 1'b0, "R11 stray read no error", 256'(rsp_err), 256'd0);

    // R7 system level request, then R3 self write clears trigger
    @(negedge clk); sys_valid = 1; sys_vector = 8'h90; sys_level = 1;
    @(negedge clk); idle();
    chk(pend_vec[8'h90] && trig_vec[8'h90], "R7 system level", trig_vec, 256'd1 << 8'h90);
    wr(12'h83F, 32'h0000_0090);
    chk(trig_vec[8'h90] == 1'b0, "R3 edge clears trigger", 256'(trig_vec[8'h90]), 256'd0);
    // R3 collision: system level wins
    @(negedge clk); sys_valid = 1; sys_vector = 8'h33; sys_level = 1;
    bus_wr = 1; bus_addr = 12'h83F; bus_wdata = 32'h33;
    @(negedge clk); idle();
    chk(trig_vec[8'h33] == 1'b1, "R3 system wins tie", 256'(trig_vec[8'h33]), 256'd1);

    // boundaries 0 and 255
    wr(12'h83F, 32'h0000_0000);
    chk(pend_vec[0] == 1'b1, "R1 vector 0", 256'(pend_vec[0]), 256'd1);
    wr(12'h83F, 32'hFFFF_FFFF);
    chk(pend_vec[255] == 1'b1 && !rsp_err, "R1 vector 255", 256'(pend_vec[255]), 256'd1);

    // R8 acknowledges
    foreach (snap[i]) ;
    @(negedge clk); ack_valid = 1; ack_vector = 8'h41;
    @(negedge clk); ack_vector = 8'hFF;
    @(negedge clk); ack_vector = 8'h00;
    @(negedge clk); idle();
    chk(!pend_vec[8'h41] && serv_vec[8'h41], "R8 ack moves 0x41", serv_vec, 256'd1 << 8'h41);
    chk(serv_vec[255] && serv_vec[0], "R8 ack 255 and 0", serv_vec, 256'd0);

    // R9 eoi removes highest
    @(negedge clk); eoi = 1;
    @(negedge clk); idle();
    chk(!serv_vec[255] && serv_vec[8'h41] && serv_vec[0], "R9 eoi highest", serv_vec, 256'd0);
    @(negedge clk); eoi = 1;
    @(negedge clk); eoi = 1;
    @(negedge clk); eoi = 1;
    @(negedge clk); idle();
    chk(serv_vec == '0, "R9 eoi on empty", serv_vec, '0);

    // R10 ack and write same vector
    wr(12'h83F, 32'h0000_0077);
    @(negedge clk); ack_valid = 1; ack_vector = 8'h77;
    bus_wr = 1; bus_addr = 12'h83F; bus_wdata = 32'h77;
    @(negedge clk); idle();
    chk(pend_vec[8'h77] && serv_vec[8'h77], "R10 collision keeps pending", pend_vec, 256'd1 << 8'h77);

    // random traffic compared against the model every cycle
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      bus_wr     = ($urandom % 4) == 0;
      bus_rd     = ($urandom % 8) == 0;
      bus_addr   = ($urandom % 3 == 0) ? 12'h83E : 12'h83F;
      bus_wdata  = {$urandom % 256 == 0 ? 24'hFFFFFF : 24'h0, 8'($urandom % 16 * 17)};
      sys_valid  = ($urandom % 5) == 0;
      sys_vector = 8'($urandom % 16 * 17);
      sys_level  = 1'($urandom);
      ack_valid  = ($urandom % 4) == 0;
      ack_vector = 8'($urandom % 16 * 17);
      eoi        = ($urandom % 4) == 0;
    end
    @(negedge clk); idle();
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule